// File: doc/BRIEF.md
# Coherent Cache Line State Controller

This block is the master-side controller for one line of a coherent cache. The line's coherency state is held as four separate flags: valid, shared, owner and dirty. Ownership, meaning the duty to write dirty data back, is kept apart from uniqueness. A local port accepts load, store and free requests. To serve them, the controller fetches or upgrades the line over a read-command stream, consumes read responses and acknowledges each one. It writes the line back or evicts it over a write-command stream. All streams use a valid/ready handshake.

The interconnect may send probe commands at any time while the controller is idle or waiting for a read response. A probe is answered in one of two ways: a plain probe-success beat, or a write-back tagged with the probe's ID and flagged as probe-generated. A makeUnique upgrade that is in flight when an invalidating probe arrives becomes weak. Its success response then no longer grants the line, and the pending store is retried with a full readUnique.

Top module: `coh_line_ctrl`

## Requirements
- R1: After reset the line is invalid (line_flags = 4'b0000, bit 3 valid, bit 2 shared, bit 1 owner, bit 0 dirty), and no outgoing stream asserts valid.
- R2: A load to an invalid line issues readShared (rcmd_op 0). When the data response arrives (rrsp_kind 2), the line takes {1, rrsp_shared, rrsp_owner, rrsp_dirty}, and the load completes with that data on lreq_rdata (lreq_op 0 = load, 1 = store, 2 = free).
- R3: A store to an invalid line issues readUnique (rcmd_op 1). The line ends as valid, unique, owner and dirty (4'b1011), whatever shared/owner bits the response carries, and it holds the store data.
- R4: A store to a valid line that is not unique-owner issues makeUnique (rcmd_op 2). Its success response (rrsp_kind 0) makes the line 4'b1011 and completes the store.
- R5: Every accepted read response is followed by exactly one readAck handshake. No new read response is accepted while the ack is pending, and the ack stays valid until taken.
- R6: A makeInvalid probe (pcmd_op 0) invalidates the line. A valid owner-dirty line is answered with writeInvalid (wcmd_op 0) carrying wcmd_probe = 1 and the probe ID. Any other line is answered with probe-success.
- R7: A makeShared probe (pcmd_op 1) sets the shared flag on a valid line. A valid owner-dirty line is answered with writeShare (wcmd_op 1) and becomes 4'b1110. Any other line gets probe-success and keeps its owner and dirty bits.
- R8: A probeOnce probe (pcmd_op 2) on a valid owner-dirty line is answered with writeUnique (wcmd_op 2) if the line is unique, or with writeShare if it is shared. The line stays valid and becomes clean. Any other line gets probe-success and is unchanged.
- R9: A makeInvalid probe accepted while a makeUnique is outstanding makes that makeUnique weak. Its success response is acknowledged but does not complete the store, and the store is then retried with readUnique.
- R10: A free of a valid owner-dirty line issues writeInvalid with wcmd_probe = 0. A free of any other valid line issues evict (wcmd_op 3). In both cases the free completes on the write response and the line ends invalid. A free of an invalid line completes at once with no write command.
- R11: An error response (rrsp_kind 1) leaves the line invalid and completes the local request with lreq_err high.
- R12: A load to a valid line, or a store to a valid unique owner line, completes in the cycle it is presented, with no read command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lreq_valid | input | 1 | Local request present, held until lreq_ready |
| lreq_op | input | 2 | 0 load, 1 store, 2 free |
| lreq_wdata | input | DW | Store data |
| lreq_ready | output | 1 | Local request completes this cycle |
| lreq_err | output | 1 | Completion carries a read error |
| lreq_rdata | output | DW | Line data |
| rcmd_valid | output | 1 | Read command valid |
| rcmd_ready | input | 1 | Read command accepted |
| rcmd_op | output | 2 | 0 readShared, 1 readUnique, 2 makeUnique |
| rrsp_valid | input | 1 | Read response valid |
| rrsp_ready | output | 1 | Read response accepted |
| rrsp_kind | input | 2 | 0 success, 1 error, 2 data |
| rrsp_shared | input | 1 | Granted copy is shared |
| rrsp_owner | input | 1 | Granted copy is owner |
| rrsp_dirty | input | 1 | Granted copy is dirty |
| rrsp_data | input | DW | Response data |
| rack_valid | output | 1 | Read acknowledge valid |
| rack_ready | input | 1 | Read acknowledge accepted |
| wcmd_valid | output | 1 | Write command valid |
| wcmd_ready | input | 1 | Write command accepted |
| wcmd_op | output | 2 | 0 writeInvalid, 1 writeShare, 2 writeUnique, 3 evict |
| wcmd_probe | output | 1 | Write answers a probe |
| wcmd_id | output | IW | Probe ID echoed on probe write-backs |
| wcmd_data | output | DW | Line data written back |
| wrsp_valid | input | 1 | Write response valid |
| wrsp_ready | output | 1 | Write response accepted |
| pcmd_valid | input | 1 | Probe command valid |
| pcmd_ready | output | 1 | Probe command accepted |
| pcmd_op | input | 2 | 0 makeInvalid, 1 makeShared, 2 probeOnce |
| pcmd_id | input | IW | Probe ID |
| prsp_valid | output | 1 | Probe-success valid |
| prsp_ready | input | 1 | Probe-success accepted |
| line_flags | output | 4 | {valid, shared, owner, dirty} |

## Verification
The weak makeUnique is the hardest case to reach. It needs a probe to land after the makeUnique command has been accepted but before its response is returned. The bench holds the read response back, injects a makeInvalid probe in that window, and only then returns success. It then checks that the store has not completed and that a second read command asks for readUnique. Probe handling is driven from a table that sets up each starting state through a load miss with chosen response flags, so every probe kind meets both dirty-owner and clean or lodger lines.

// File: rtl/coh_line_pkg.sv
package coh_line_pkg;
  typedef struct packed {
    logic v;
    logic s;
    logic o;
    logic d;
  } line_flags_t;

  localparam logic [1:0] RD_SHARED = 2'd0;
  localparam logic [1:0] RD_UNIQUE = 2'd1;
  localparam logic [1:0] RD_MKUNIQ = 2'd2;

  localparam logic [1:0] WB_INVAL  = 2'd0;
  localparam logic [1:0] WB_SHARE  = 2'd1;
  localparam logic [1:0] WB_UNIQ   = 2'd2;
  localparam logic [1:0] WB_EVICT  = 2'd3;

  localparam logic [1:0] PB_INVAL  = 2'd0;
  localparam logic [1:0] PB_SHARE  = 2'd1;

  localparam logic [1:0] LQ_STORE  = 2'd1;
  localparam logic [1:0] LQ_FREE   = 2'd2;

  localparam logic [1:0] RS_OK     = 2'd0;
  localparam logic [1:0] RS_DATA   = 2'd2;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RCMD, ST_RWAIT, ST_RACK, ST_WCMD, ST_WWAIT, ST_PRSP
  } ctl_st_t;
endpackage

// File: rtl/coh_line_rst_sync.sv
module coh_line_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic srst_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign srst_n = sync_q[1];
endmodule

// File: rtl/coh_line_store.sv
module coh_line_store
  import coh_line_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fl_we,
  input  line_flags_t   fl_in,
  input  logic          dt_we,
  input  logic [DW-1:0] dt_in,
  output line_flags_t   fl_q,
  output logic [DW-1:0] dt_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     fl_q <= '0;
    else if (fl_we) fl_q <= fl_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     dt_q <= '0;
    else if (dt_we) dt_q <= dt_in;
  end
endmodule

// File: rtl/coh_line_probe_dec.sv
module coh_line_probe_dec
  import coh_line_pkg::*;
(
  input  line_flags_t cur,
  input  logic [1:0]  op,
  output line_flags_t nxt,
  output logic        wb_need,
  output logic [1:0]  wb_op,
  output logic        chg
);
  logic vod;
  assign vod = cur.v & cur.o & cur.d;

  always_comb begin
    nxt     = cur;
    wb_need = vod;
    wb_op   = WB_INVAL;
    case (op)
      PB_INVAL: begin
        nxt   = '0;
        wb_op = WB_INVAL;
      end
      PB_SHARE: begin
        nxt.s = cur.v;
        nxt.d = cur.d & ~vod;
        wb_op = WB_SHARE;
      end
      default: begin
        nxt.d = cur.d & ~vod;
        wb_op = cur.s ? WB_SHARE : WB_UNIQ;
      end
    endcase
    chg = cur.v & ((nxt.v != cur.v) | (nxt.s != cur.s));
  end
endmodule

// File: rtl/coh_line_ctrl.sv
module coh_line_ctrl
  import coh_line_pkg::*;
#(
  parameter int DW = 8,
  parameter int IW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          lreq_valid,
  input  logic [1:0]    lreq_op,
  input  logic [DW-1:0] lreq_wdata,
  output logic          lreq_ready,
  output logic          lreq_err,
  output logic [DW-1:0] lreq_rdata,
  output logic          rcmd_valid,
  input  logic          rcmd_ready,
  output logic [1:0]    rcmd_op,
  input  logic          rrsp_valid,
  output logic          rrsp_ready,
  input  logic [1:0]    rrsp_kind,
  input  logic          rrsp_shared,
  input  logic          rrsp_owner,
  input  logic          rrsp_dirty,
  input  logic [DW-1:0] rrsp_data,
  output logic          rack_valid,
  input  logic          rack_ready,
  output logic          wcmd_valid,
  input  logic          wcmd_ready,
  output logic [1:0]    wcmd_op,
  output logic          wcmd_probe,
  output logic [IW-1:0] wcmd_id,
  output logic [DW-1:0] wcmd_data,
  input  logic          wrsp_valid,
  output logic          wrsp_ready,
  input  logic          pcmd_valid,
  output logic          pcmd_ready,
  input  logic [1:0]    pcmd_op,
  input  logic [IW-1:0] pcmd_id,
  output logic          prsp_valid,
  input  logic          prsp_ready,
  output logic [3:0]    line_flags
);
  logic          srst_n;
  ctl_st_t       st_q, st_d;
  logic [1:0]    rop_q, rop_d, wop_q, wop_d;
  logic          weak_q, weak_d, rpend_q, rpend_d, err_q, err_d, wprb_q, wprb_d;
  logic [IW-1:0] wid_q, wid_d;
  line_flags_t   fl_q, fl_in, pd_nxt;
  logic          fl_we, dt_we, pd_wb, pd_chg, vod;
  logic [1:0]    pd_wop;
  logic [DW-1:0] dt_q, dt_in;

  coh_line_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .srst_n(srst_n));

  coh_line_store #(.DW(DW)) u_store (
    .clk(clk), .rst_n(srst_n), .fl_we(fl_we), .fl_in(fl_in),
    .dt_we(dt_we), .dt_in(dt_in), .fl_q(fl_q), .dt_q(dt_q)
  );

  coh_line_probe_dec u_pdec (
    .cur(fl_q), .op(pcmd_op), .nxt(pd_nxt),
    .wb_need(pd_wb), .wb_op(pd_wop), .chg(pd_chg)
  );

  assign vod = fl_q.v & fl_q.o & fl_q.d;

  always_comb begin
    st_d = st_q;   rop_d = rop_q;   weak_d = weak_q; rpend_d = rpend_q;
    err_d = err_q; wop_d = wop_q;   wprb_d = wprb_q; wid_d = wid_q;
    fl_we = 1'b0;  fl_in = fl_q;    dt_we = 1'b0;    dt_in = lreq_wdata;
    lreq_ready = 1'b0; lreq_err = 1'b0; rcmd_valid = 1'b0; rrsp_ready = 1'b0;
    rack_valid = 1'b0; wcmd_valid = 1'b0; wrsp_ready = 1'b0;
    pcmd_ready = 1'b0; prsp_valid = 1'b0;
    if (((st_q == ST_IDLE) || (st_q == ST_RWAIT)) && pcmd_valid) begin
      pcmd_ready = 1'b1;
      fl_we      = 1'b1;
      fl_in      = pd_nxt;
      if ((st_q == ST_RWAIT) && (rop_q == RD_MKUNIQ) && pd_chg) weak_d = 1'b1;
      if (pd_wb) begin
        wop_d = pd_wop; wprb_d = 1'b1; wid_d = pcmd_id; st_d = ST_WCMD;
      end else begin
        st_d = ST_PRSP;
      end
    end else begin
      case (st_q)
        ST_IDLE: if (lreq_valid) begin
          case (lreq_op)
            LQ_STORE: if (fl_q.v & ~fl_q.s & fl_q.o) begin
              lreq_ready = 1'b1; fl_we = 1'b1; fl_in.d = 1'b1; dt_we = 1'b1;
            end else begin
              rop_d = fl_q.v ? RD_MKUNIQ : RD_UNIQUE; weak_d = 1'b0; st_d = ST_RCMD;
            end
            LQ_FREE: if (!fl_q.v) begin
              lreq_ready = 1'b1;
            end else begin
              fl_we = 1'b1; fl_in = '0; wop_d = vod ? WB_INVAL : WB_EVICT;
              wprb_d = 1'b0; wid_d = '0; st_d = ST_WCMD;
            end
            default: if (fl_q.v) begin
              lreq_ready = 1'b1;
            end else begin
              rop_d = RD_SHARED; weak_d = 1'b0; st_d = ST_RCMD;
            end
          endcase
        end
        ST_RCMD: begin
          rcmd_valid = 1'b1;
          if (rcmd_ready) begin rpend_d = 1'b1; st_d = ST_RWAIT; end
        end
        ST_RWAIT: begin
          rrsp_ready = 1'b1;
          if (rrsp_valid) begin
            rpend_d = 1'b0; err_d = 1'b0; st_d = ST_RACK;
            case (rrsp_kind)
              RS_DATA: begin
                fl_we = 1'b1; dt_we = 1'b1; dt_in = rrsp_data;
                if (rop_q == RD_SHARED)
                  fl_in = '{v: 1'b1, s: rrsp_shared, o: rrsp_owner, d: rrsp_dirty};
                else
                  fl_in = '{v: 1'b1, s: 1'b0, o: 1'b1, d: rrsp_dirty};
              end
              RS_OK: if (!weak_q && (rop_q == RD_MKUNIQ)) begin
                fl_we = 1'b1; fl_in.v = 1'b1; fl_in.s = 1'b0; fl_in.o = 1'b1;
              end
              default: begin fl_we = 1'b1; fl_in = '0; err_d = 1'b1; end
            endcase
          end
        end
        ST_RACK: begin
          rack_valid = 1'b1;
          if (rack_ready) begin
            st_d = ST_IDLE;
            if (!weak_q) begin
              lreq_ready = 1'b1;
              lreq_err   = err_q;
              if (!err_q && (rop_q != RD_SHARED)) begin
                fl_we = 1'b1; fl_in.d = 1'b1; dt_we = 1'b1;
              end
            end
          end
        end
        ST_WCMD: begin
          wcmd_valid = 1'b1;
          if (wcmd_ready) st_d = ST_WWAIT;
        end
        ST_WWAIT: begin
          wrsp_ready = 1'b1;
          if (wrsp_valid) begin
            lreq_ready = ~wprb_q;
            st_d = rpend_q ? ST_RWAIT : ST_IDLE;
          end
        end
        default: begin
          prsp_valid = 1'b1;
          if (prsp_ready) st_d = rpend_q ? ST_RWAIT : ST_IDLE;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      st_q <= ST_IDLE; rop_q <= RD_SHARED; wop_q <= WB_INVAL; weak_q <= 1'b0;
      rpend_q <= 1'b0; err_q <= 1'b0; wprb_q <= 1'b0; wid_q <= '0;
    end else begin
      st_q <= st_d; rop_q <= rop_d; wop_q <= wop_d; weak_q <= weak_d;
      rpend_q <= rpend_d; err_q <= err_d; wprb_q <= wprb_d; wid_q <= wid_d;
    end
  end

  assign lreq_rdata = dt_q;
  assign rcmd_op    = rop_q;
  assign wcmd_op    = wop_q;
  assign wcmd_probe = wprb_q;
  assign wcmd_id    = wid_q;
  assign wcmd_data  = dt_q;
  assign line_flags = fl_q;
endmodule

// File: rtl/coh_line_chk.sv
module coh_line_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       rcmd_valid,
  input logic [1:0] rcmd_op,
  input logic       rrsp_valid,
  input logic       rrsp_ready,
  input logic       rack_valid,
  input logic       rack_ready,
  input logic       wcmd_valid,
  input logic       wcmd_ready,
  input logic [1:0] wcmd_op,
  input logic       lreq_ready,
  input logic       lreq_err,
  input logic [3:0] line_flags
);
  // R5
  rack_after_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rrsp_valid && rrsp_ready) |=> rack_valid);
  // R5
  rack_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rack_valid && !rack_ready) |=> rack_valid);
  // R5
  no_rsp_during_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rack_valid |-> !rrsp_ready);
  // R2
  fetch_from_invalid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rcmd_valid && rcmd_op != 2'd2) |-> !line_flags[3]);
  // R4
  upgrade_from_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rcmd_valid && rcmd_op == 2'd2) |-> line_flags[3]);
  // R6
  wcmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wcmd_valid && !wcmd_ready) |=> (wcmd_valid && $stable(wcmd_op)));
  // R10
  wrinv_leaves_invalid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wcmd_valid && wcmd_op == 2'd0) |-> !line_flags[3]);
  // R11
  err_completes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lreq_err |-> (lreq_ready && line_flags == 4'b0000));
endmodule

bind coh_line_ctrl coh_line_chk u_chk (
  .clk(clk), .rst_n(rst_n), .rcmd_valid(rcmd_valid), .rcmd_op(rcmd_op),
  .rrsp_valid(rrsp_valid), .rrsp_ready(rrsp_ready), .rack_valid(rack_valid),
  .rack_ready(rack_ready), .wcmd_valid(wcmd_valid), .wcmd_ready(wcmd_ready),
  .wcmd_op(wcmd_op), .lreq_ready(lreq_ready), .lreq_err(lreq_err),
  .line_flags(line_flags)
);

// File: tb/coh_line_ctrl_bench.sv
module coh_line_ctrl_bench;
  logic       clk = 1'b0, rst_n = 1'b0;
  logic       lreq_valid = 1'b0; logic [1:0] lreq_op = 2'd0; logic [7:0] lreq_wdata = 8'd0;
  logic       lreq_ready, lreq_err; logic [7:0] lreq_rdata;
  logic       rcmd_valid; logic rcmd_ready = 1'b1; logic [1:0] rcmd_op;
  logic       rrsp_valid = 1'b0, rrsp_ready; logic [1:0] rrsp_kind = 2'd0;
  logic       rrsp_shared = 1'b0, rrsp_owner = 1'b0, rrsp_dirty = 1'b0; logic [7:0] rrsp_data = 8'd0;
  logic       rack_valid; logic rack_ready = 1'b1;
  logic       wcmd_valid; logic wcmd_ready = 1'b1; logic [1:0] wcmd_op; logic wcmd_probe;
  logic [3:0] wcmd_id; logic [7:0] wcmd_data;
  logic       wrsp_valid = 1'b0, wrsp_ready;
  logic       pcmd_valid = 1'b0, pcmd_ready; logic [1:0] pcmd_op = 2'd0; logic [3:0] pcmd_id = 4'd0;
  logic       prsp_valid; logic prsp_ready = 1'b1;
  logic [3:0] line_flags;

  int n_chk = 0, n_fail = 0;
  int n_rcmd = 0, n_rrsp = 0, n_rack = 0, n_wcmd = 0, n_prsp = 0, n_done = 0;
  logic [1:0] last_rop, last_wop; logic [3:0] last_wid; logic last_wprb, last_err;
  logic [7:0] last_rdata, last_wdata;

  always #2 clk = ~clk;

  coh_line_ctrl u_coh_line_ctrl (.*);

  always @(posedge clk) begin
    if (rcmd_valid && rcmd_ready) begin n_rcmd++; last_rop = rcmd_op; end
    if (rrsp_valid && rrsp_ready) n_rrsp++;
    if (rack_valid && rack_ready) n_rack++;
    if (wcmd_valid && wcmd_ready) begin
      n_wcmd++; last_wop = wcmd_op; last_wid = wcmd_id; last_wprb = wcmd_probe; last_wdata = wcmd_data;
    end
    if (prsp_valid && prsp_ready) n_prsp++;
    if (lreq_ready) begin n_done++; last_err = lreq_err; last_rdata = lreq_rdata; end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic lreq_go(logic [1:0] op, logic [7:0] wd);
    @(negedge clk); lreq_valid = 1'b1; lreq_op = op; lreq_wdata = wd;
  endtask

  task automatic lreq_end(int d0);
    wait (n_done > d0);
    @(negedge clk); lreq_valid = 1'b0;
  endtask

  task automatic send_rsp(logic [1:0] k, logic s, logic o, logic d, logic [7:0] dat);
    @(negedge clk);
    rrsp_valid = 1'b1; rrsp_kind = k; rrsp_shared = s; rrsp_owner = o; rrsp_dirty = d; rrsp_data = dat;
    #1;
    while (!rrsp_ready) begin @(negedge clk); #1; end
    @(negedge clk); rrsp_valid = 1'b0;
  endtask

  task automatic send_probe(logic [1:0] op, logic [3:0] id);
    @(negedge clk); pcmd_valid = 1'b1; pcmd_op = op; pcmd_id = id;
    #1;
    while (!pcmd_ready) begin @(negedge clk); #1; end
    @(negedge clk); pcmd_valid = 1'b0;
  endtask

  task automatic serve_wr(int w0);
    wait (n_wcmd > w0);
    @(negedge clk); wrsp_valid = 1'b1;
    #1;
    while (!wrsp_ready) begin @(negedge clk); #1; end
    @(negedge clk); wrsp_valid = 1'b0;
  endtask

  task automatic fill(logic s, logic o, logic d, logic [7:0] dat);
    int r0 = n_rcmd; int d0 = n_done;
    lreq_go(2'd0, 8'd0);
    wait (n_rcmd > r0);
    chk("R2 fetch is readShared", last_rop, 2'd0);
    send_rsp(2'd2, s, o, d, dat);
    lreq_end(d0);
  endtask

  task automatic drop_line();
    int w0 = n_wcmd; int d0 = n_done;
    @(negedge clk);
    if (line_flags[3]) begin
      lreq_go(2'd2, 8'd0);
      serve_wr(w0);
      lreq_end(d0);
    end
  endtask

  // probe table: [11:10] probe op, [9] shared, [8] owner, [7] dirty,
  // [6] write-back expected, [5:4] write op, [3:0] final flags
  localparam logic [11:0] PTAB [8] = '{
    12'b000111000000, 12'b001100000000, 12'b010111011110, 12'b010000001100,
    12'b100111101010, 12'b101111011110, 12'b101000001100, 12'b011010001101
  };

  initial begin
    repeat (50000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int r0, d0, w0, p0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk("R1 flags", line_flags, 4'b0000);
    chk("R1 stream valids", {rcmd_valid, rack_valid, wcmd_valid, prsp_valid, lreq_ready}, 5'b0);

    // probe table walk (R6, R7, R8)
    for (int i = 0; i < 8; i++) begin
      string tg;
      tg = (PTAB[i][11:10] == 2'd0) ? "R6" : (PTAB[i][11:10] == 2'd1) ? "R7" : "R8";
      fill(PTAB[i][9], PTAB[i][8], PTAB[i][7], 8'h40 + 8'(i));
      p0 = n_prsp; w0 = n_wcmd;
      send_probe(PTAB[i][11:10], 4'(i));
      if (PTAB[i][6]) begin
        serve_wr(w0);
        chk({tg, " write op"}, last_wop, PTAB[i][5:4]);
        chk({tg, " write id/probe"}, {last_wprb, last_wid}, {1'b1, 4'(i)});
        chk({tg, " write data"}, last_wdata, 8'h40 + 8'(i));
      end else begin
        wait (n_prsp > p0);
        chk({tg, " no write"}, n_wcmd, w0);
      end
      @(negedge clk);
      chk({tg, " flags"}, line_flags, PTAB[i][3:0]);
      drop_line();
    end

    // R2 load miss installs response flags and data
    fill(1'b1, 1'b0, 1'b0, 8'h5A);
    @(negedge clk);
    chk("R2 flags", line_flags, 4'b1100);
    chk("R2 data", last_rdata, 8'h5A);
    // R4 store on shared line: makeUnique then success
    r0 = n_rcmd; d0 = n_done;
    lreq_go(2'd1, 8'h22);
    wait (n_rcmd > r0);
    chk("R4 op makeUnique", last_rop, 2'd2);
    send_rsp(2'd0, 1'b0, 1'b0, 1'b0, 8'h00);
    lreq_end(d0);
    chk("R4 flags", line_flags, 4'b1011);
    // R12 load hit: no read command
    r0 = n_rcmd; d0 = n_done;
    lreq_go(2'd0, 8'd0); lreq_end(d0);
    chk("R12 no read", n_rcmd, r0);
    chk("R12 data", last_rdata, 8'h22);

    // R10 free of dirty owner: local writeInvalid
    w0 = n_wcmd; d0 = n_done;
    lreq_go(2'd2, 8'd0); serve_wr(w0); lreq_end(d0);
    chk("R10 op/probe", {last_wprb, last_wop}, {1'b0, 2'd0});
    chk("R10 flags", line_flags, 4'b0000);
    // R10 free of invalid line
    w0 = n_wcmd; d0 = n_done;
    lreq_go(2'd2, 8'd0); lreq_end(d0);
    chk("R10 no write", n_wcmd, w0);
    // R10 clean valid line: evict
    fill(1'b0, 1'b1, 1'b0, 8'h66);
    w0 = n_wcmd; d0 = n_done;
    lreq_go(2'd2, 8'd0); serve_wr(w0); lreq_end(d0);
    chk("R10 evict", last_wop, 2'd3);

    // R3 store miss: readUnique, forced unique owner dirty
    r0 = n_rcmd; d0 = n_done;
    lreq_go(2'd1, 8'hA5);
    wait (n_rcmd > r0);
    chk("R3 op readUnique", last_rop, 2'd1);
    send_rsp(2'd2, 1'b1, 1'b0, 1'b0, 8'h11);
    lreq_end(d0);
    chk("R3 flags", line_flags, 4'b1011);
    d0 = n_done; r0 = n_rcmd;
    lreq_go(2'd1, 8'hB6); lreq_end(d0);
    chk("R12 store hit no read", n_rcmd, r0);
    d0 = n_done;
    lreq_go(2'd0, 8'd0); lreq_end(d0);
    chk("R3 data", last_rdata, 8'hB6);
    drop_line();

    // R11 read error
    r0 = n_rcmd; d0 = n_done;
    lreq_go(2'd0, 8'd0);
    wait (n_rcmd > r0);
    send_rsp(2'd1, 1'b0, 1'b0, 1'b0, 8'h00);
    lreq_end(d0);
    chk("R11 err", last_err, 1'b1);
    chk("R11 flags", line_flags, 4'b0000);

    // R9 weak makeUnique
    fill(1'b1, 1'b1, 1'b0, 8'h30);
    r0 = n_rcmd; d0 = n_done; p0 = n_prsp;
    lreq_go(2'd1, 8'h33);
    wait (n_rcmd > r0);
    chk("R9 first op makeUnique", last_rop, 2'd2);
    send_probe(2'd0, 4'd5);
    wait (n_prsp > p0);
    send_rsp(2'd0, 1'b0, 1'b0, 1'b0, 8'h00);
    wait (n_rcmd > r0 + 1);
    chk("R9 store not done", n_done, d0);
    chk("R9 retry readUnique", last_rop, 2'd1);
    send_rsp(2'd2, 1'b0, 1'b1, 1'b0, 8'h44);
    lreq_end(d0);
    chk("R9 flags", line_flags, 4'b1011);
    d0 = n_done;
    lreq_go(2'd0, 8'd0); lreq_end(d0);
    chk("R9 data", last_rdata, 8'h33);

    // R5 one ack per response
    @(negedge clk);
    chk("R5 ack count", n_rack, n_rrsp);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule